// File: doc/BRIEF.md
# Per-CPU Inter-Processor Interrupt Unit

This block carries interrupt signalling between a small set of CPUs. Each CPU owns two interchangeable doorbell sources, "other" and "self". Each source has a pending bit and a mask bit. A CPU raises the "other" source on any group of CPUs with one write that carries one bit per destination. Acknowledge, mask-set and mask-clear writes act on the CPU that issues them. Optional per-CPU register windows let any requester reach the pending and mask bits of a chosen CPU directly, and the "self" source is raised through these windows.

Writes and event reads travel on separate channels, and each channel names its requesting CPU, so the block can serve a "this CPU" view and a who-am-I readback. A read of the event register returns the word from the main hardware priority encoder when that encoder has one. Otherwise it returns the highest unmasked pending doorbell of the reading CPU, and that source is masked as it is reported. A per-CPU request line, high while any source is pending and unmasked, feeds the main priority encoder.

Top module: `ipi_unit`

## Requirements
- R1: After reset no source is pending, both sources of every CPU are masked, every `ipiIrq` line is low and an event read returns 0.
- R2: A read at offset 0x000 returns the index of the reading CPU (`rdCpu`), zero-extended.
- R3: A write at offset 0x008 sets the "other" pending bit of CPU n for each set data bit n. A repeated send to an already pending CPU leaves a single pending bit, which one acknowledge clears.
- R4: A write at offset 0x00C clears the requesting CPU's pending bits, with data bit 0 for "other" and bit 31 for "self", write-one-to-act. Other CPUs are not affected.
- R5: Writes at offsets 0x010 (mask set) and 0x014 (mask clear) act on the requesting CPU's mask bits, with data bit 0 for "other" and bit 31 for "self". A masked pending source raises no request.
- R6: When `hwEvtValid` is high, an event read at offset 0x004 returns `hwEvtWord` and changes no doorbell mask.
- R7: Otherwise an event read returns type 4 in bits 23:16 and number 1 ("other") or 2 ("self") in bits 15:0, with "other" ahead of "self". With nothing unmasked and pending it returns 0.
- R8: Reporting a doorbell through an event read sets that source's mask bit and keeps its pending bit. It is not reported again until its mask is cleared.
- R9: With windows enabled, CPU c's window starts at 0x400 + 128*c. Its offsets are +0x08 pending set, +0x0C pending clear, +0x10 mask set and +0x14 mask clear, with bit 0 for "other" and bit 31 for "self".
- R10: An event read returns the state from before any write in the same cycle. When an auto-mask and a mask-clear hit the same source in one cycle, the auto-mask wins.
- R11: `ipiIrq[c]` is high exactly when CPU c has a source that is both pending and unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrCpu | input | CPU_W | Index of the writing CPU |
| wrAddr | input | AW | Write byte offset |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read strobe |
| rdCpu | input | CPU_W | Index of the reading CPU |
| rdAddr | input | AW | Read byte offset |
| rdData | output | 32 | Read data, combinational in the read cycle |
| hwEvtValid | input | 1 | Main encoder holds an event for the reading CPU |
| hwEvtWord | input | 32 | Event word from the main encoder |
| ipiIrq | output | NUM_CPUS | Per-CPU doorbell request toward the main encoder |

## Verification
An event read by one CPU and a write from the other channel can land in the same cycle. The conflict that matters is an auto-mask and a mask-clear on the same source, and the case where a send arrives while the target is reading its event register. The bench drives both channels in one cycle. It judges the returned word against the state before the write, and it judges the outcome by the request line and by later event reads.

// File: rtl/ipi_unit_pkg.sv
package ipi_unit_pkg;
  localparam int OFF_WHOAMI = 'h000;
  localparam int OFF_EVENT  = 'h004;
  localparam int OFF_SEND   = 'h008;
  localparam int OFF_ACK    = 'h00C;
  localparam int OFF_MSET   = 'h010;
  localparam int OFF_MCLR   = 'h014;

  localparam int WIN_STRIDE = 128;
  localparam int WIN_SET    = 'h08;
  localparam int WIN_CLR    = 'h0C;
  localparam int WIN_MSET   = 'h10;
  localparam int WIN_MCLR   = 'h14;

  localparam logic [7:0]  EVT_TYPE_IPI = 8'd4;
  localparam logic [31:0] EVT_OTHER    = {8'h00, EVT_TYPE_IPI, 16'd1};
  localparam logic [31:0] EVT_SELF     = {8'h00, EVT_TYPE_IPI, 16'd2};

  // index 0 = "other" source, index 1 = "self" source
  typedef struct packed {
    logic [1:0] pendSet;
    logic [1:0] pendClr;
    logic [1:0] maskSet;
    logic [1:0] maskClr;
    logic [1:0] autoMask;
  } ipiStrobe_t;

  function automatic logic [1:0] srcBits(input logic [31:0] d);
    return {d[31], d[0]};
  endfunction
endpackage

// File: rtl/ipi_state.sv
module ipi_state
  import ipi_unit_pkg::*;
#(
  parameter int NUM_CPUS = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  ipiStrobe_t [NUM_CPUS-1:0]        strb,
  output logic       [NUM_CPUS-1:0][1:0]   pendQ,
  output logic       [NUM_CPUS-1:0][1:0]   maskQ,
  output logic       [NUM_CPUS-1:0]        ipiIrq
);
  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendQ[c] <= 2'b00;
        maskQ[c] <= 2'b11;
      end else begin
        pendQ[c] <= (pendQ[c] & ~strb[c].pendClr) | strb[c].pendSet;
        maskQ[c] <= ((maskQ[c] & ~strb[c].maskClr) | strb[c].maskSet) | strb[c].autoMask;
      end
    end
    assign ipiIrq[c] = |(pendQ[c] & ~maskQ[c]);
  end
endmodule

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_unit_pkg::*;
#(
  parameter int          NUM_CPUS = 4,
  parameter int          AW       = 16,
  parameter bit          WIN_EN   = 1'b1,
  parameter int          WIN_BASE = 'h400,
  localparam int         CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                           wrEn,
  input  logic [CPU_W-1:0]               wrCpu,
  input  logic [AW-1:0]                  wrAddr,
  input  logic [31:0]                    wrData,
  input  logic                           rdEn,
  input  logic [CPU_W-1:0]               rdCpu,
  input  logic [AW-1:0]                  rdAddr,
  input  logic                           hwEvtValid,
  input  logic [31:0]                    hwEvtWord,
  input  logic [NUM_CPUS-1:0][1:0]       pendQ,
  input  logic [NUM_CPUS-1:0][1:0]       maskQ,
  output ipiStrobe_t [NUM_CPUS-1:0]      strb,
  output logic [31:0]                    rdData
);
  logic             winHit;
  logic [CPU_W-1:0] winCpu;
  logic [6:0]       winOff;
  logic [1:0]       wrSrc;
  logic [1:0]       live;
  logic             evtRd;
  logic             unusedWrData;

  assign unusedWrData = ^wrData;
  assign wrSrc = srcBits(wrData);

  if (WIN_EN) begin : g_win
    logic [AW-1:0] winRel;
    assign winRel = wrAddr - AW'(WIN_BASE);
    assign winHit = (wrAddr >= AW'(WIN_BASE)) && (winRel < AW'(NUM_CPUS * WIN_STRIDE));
    assign winCpu = CPU_W'(winRel >> 7);
    assign winOff = winRel[6:0];
  end else begin : g_nowin
    assign winHit = 1'b0;
    assign winCpu = '0;
    assign winOff = '0;
  end

  always_comb begin
    live = 2'b00;
    for (int c = 0; c < NUM_CPUS; c++)
      if (c == int'(rdCpu)) live = pendQ[c] & ~maskQ[c];
  end

  assign evtRd = rdEn && (rdAddr == AW'(OFF_EVENT));

  always_comb begin
    strb = '0;
    for (int c = 0; c < NUM_CPUS; c++) begin
      if (wrEn) begin
        if (wrAddr == AW'(OFF_SEND)) strb[c].pendSet[0] = wrData[c];
        if (c == int'(wrCpu)) begin
          if (wrAddr == AW'(OFF_ACK))  strb[c].pendClr = wrSrc;
          if (wrAddr == AW'(OFF_MSET)) strb[c].maskSet = wrSrc;
          if (wrAddr == AW'(OFF_MCLR)) strb[c].maskClr = wrSrc;
        end
        if (winHit && c == int'(winCpu)) begin
          if (winOff == 7'(WIN_SET))  strb[c].pendSet = wrSrc;
          if (winOff == 7'(WIN_CLR))  strb[c].pendClr = wrSrc;
          if (winOff == 7'(WIN_MSET)) strb[c].maskSet = wrSrc;
          if (winOff == 7'(WIN_MCLR)) strb[c].maskClr = wrSrc;
        end
      end
      if (evtRd && !hwEvtValid && c == int'(rdCpu)) begin
        if (live[0])      strb[c].autoMask = 2'b01;
        else if (live[1]) strb[c].autoMask = 2'b10;
      end
    end
  end

  always_comb begin
    rdData = 32'h0;
    if (rdEn) begin
      if (rdAddr == AW'(OFF_WHOAMI)) rdData = 32'(rdCpu);
      else if (evtRd) begin
        if (hwEvtValid)   rdData = hwEvtWord;
        else if (live[0]) rdData = EVT_OTHER;
        else if (live[1]) rdData = EVT_SELF;
      end
    end
  end
endmodule

// File: rtl/ipi_unit.sv
module ipi_unit
  import ipi_unit_pkg::*;
#(
  parameter int  NUM_CPUS = 4,
  parameter int  AW       = 16,
  parameter bit  WIN_EN   = 1'b1,
  parameter int  WIN_BASE = 'h400,
  localparam int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [CPU_W-1:0]    wrCpu,
  input  logic [AW-1:0]       wrAddr,
  input  logic [31:0]         wrData,
  input  logic                rdEn,
  input  logic [CPU_W-1:0]    rdCpu,
  input  logic [AW-1:0]       rdAddr,
  output logic [31:0]         rdData,
  input  logic                hwEvtValid,
  input  logic [31:0]         hwEvtWord,
  output logic [NUM_CPUS-1:0] ipiIrq
);
  ipiStrobe_t [NUM_CPUS-1:0]  strb;
  logic [NUM_CPUS-1:0][1:0]   pendQ;
  logic [NUM_CPUS-1:0][1:0]   maskQ;

  ipi_ctrl #(
    .NUM_CPUS(NUM_CPUS), .AW(AW), .WIN_EN(WIN_EN), .WIN_BASE(WIN_BASE)
  ) ctrl_i (
    .wrEn(wrEn), .wrCpu(wrCpu), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdCpu(rdCpu), .rdAddr(rdAddr),
    .hwEvtValid(hwEvtValid), .hwEvtWord(hwEvtWord),
    .pendQ(pendQ), .maskQ(maskQ), .strb(strb), .rdData(rdData)
  );

  ipi_state #(.NUM_CPUS(NUM_CPUS)) state_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .pendQ(pendQ), .maskQ(maskQ), .ipiIrq(ipiIrq)
  );
endmodule

// File: rtl/ipi_unit_chk.sv
module ipi_unit_chk
  import ipi_unit_pkg::*;
#(
  parameter int  NUM_CPUS = 4,
  parameter int  AW       = 16,
  localparam int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     wrEn,
  input logic [CPU_W-1:0]         wrCpu,
  input logic [AW-1:0]            wrAddr,
  input logic [31:0]              wrData,
  input logic                     rdEn,
  input logic [CPU_W-1:0]         rdCpu,
  input logic [AW-1:0]            rdAddr,
  input logic [31:0]              rdData,
  input logic                     hwEvtValid,
  input logic [31:0]              hwEvtWord,
  input logic [NUM_CPUS-1:0]      ipiIrq,
  input logic [NUM_CPUS-1:0][1:0] pendQ,
  input logic [NUM_CPUS-1:0][1:0] maskQ
);
  a_r2_whoami: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == AW'(OFF_WHOAMI)) |-> rdData == 32'(rdCpu))
    else $error("R2 who-am-I mismatch");

  a_r6_hw_first: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == AW'(OFF_EVENT) && hwEvtValid) |-> rdData == hwEvtWord)
    else $error("R6 hardware event not first");

  a_r7_quiet_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == AW'(OFF_EVENT) && !hwEvtValid && !ipiIrq[rdCpu]) |-> rdData == 32'h0)
    else $error("R7 event word without request");

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    a_r3_send_sets: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrAddr == AW'(OFF_SEND) && wrData[c]) |=> pendQ[c][0])
      else $error("R3 send did not set pending");

    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrAddr == AW'(OFF_ACK) && wrCpu == CPU_W'(c) && wrData[0]) |=> !pendQ[c][0])
      else $error("R4 ack did not clear");

    a_r8_auto_mask: assert property (@(posedge clk) disable iff (!rstN)
      (rdEn && rdAddr == AW'(OFF_EVENT) && !hwEvtValid && rdCpu == CPU_W'(c) && rdData == EVT_OTHER)
      |=> maskQ[c][0])
      else $error("R8 reported source not masked");
  end
endmodule

bind ipi_unit ipi_unit_chk #(.NUM_CPUS(NUM_CPUS), .AW(AW)) chk_i (.*);

// File: tb/ipi_unit_tb_top.sv
module ipi_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int AW = 16;
  localparam logic [31:0] EOTH = 32'h0004_0001;
  localparam logic [31:0] ESLF = 32'h0004_0002;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrCpu = '0;
  logic [AW-1:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic rdEn = 1'b0;
  logic [1:0] rdCpu = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [31:0] rdData;
  logic hwEvtValid = 1'b0;
  logic [31:0] hwEvtWord = '0;
  logic [NC-1:0] ipiIrq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_unit #(.NUM_CPUS(NC), .AW(AW)) dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input int cpu, input int addr, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrCpu = 2'(cpu); wrAddr = AW'(addr); wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic rd(input int cpu, input int addr, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; rdCpu = 2'(cpu); rdAddr = AW'(addr);
    #1 d = rdData;
    @(posedge clk); #1;
    rdEn = 1'b0;
  endtask

  task automatic rdWr(input int rc, input int wc, input int waddr, input logic [31:0] wd,
                      output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; rdCpu = 2'(rc); rdAddr = AW'('h004);
    wrEn = 1'b1; wrCpu = 2'(wc); wrAddr = AW'(waddr); wrData = wd;
    #1 d = rdData;
    @(posedge clk); #1;
    rdEn = 1'b0; wrEn = 1'b0;
  endtask

  task automatic irqIs(input string tag, input logic [NC-1:0] exp);
    @(negedge clk);
    chk(tag, 32'(ipiIrq), 32'(exp));
  endtask

  task automatic t_reset;
    logic [31:0] d;
    irqIs("R1 irq after reset", 4'b0000);
    rd(0, 'h004, d); chk("R1 event after reset", d, 0);
    rd(2, 'h000, d); chk("R2 whoami cpu2", d, 2);
    rd(3, 'h000, d); chk("R2 whoami cpu3", d, 3);
  endtask

  task automatic t_send;
    for (int c = 0; c < NC; c++) wr(c, 'h014, 32'h1);
    irqIs("R5 unmask with nothing pending", 4'b0000);
    wr(0, 'h008, 32'h5);
    irqIs("R3 R11 send to cpu0 and cpu2", 4'b0101);
    wr(1, 'h008, 32'h1);
    wr(3, 'h008, 32'h1);
    wr(0, 'h00C, 32'h1);
    irqIs("R3 R4 single ack clears repeated sends, cpu2 untouched", 4'b0100);
    wr(2, 'h00C, 32'h1);
    irqIs("R4 cpu2 ack", 4'b0000);
  endtask

  task automatic t_event;
    logic [31:0] d;
    wr(0, 'h008, 32'h2);
    irqIs("R3 send to cpu1", 4'b0010);
    rd(1, 'h004, d); chk("R7 other code", d, EOTH);
    irqIs("R8 auto-mask drops request", 4'b0000);
    rd(1, 'h004, d); chk("R8 no second report", d, 0);
    wr(1, 'h014, 32'h1);
    irqIs("R8 pending kept, mask clear re-presents", 4'b0010);
    wr(1, 'h00C, 32'h1);
    irqIs("R4 ack after report", 4'b0000);
  endtask

  task automatic t_window;
    logic [31:0] d;
    wr(0, 'h588, 32'h8000_0000);
    irqIs("R5 R9 self pending but masked", 4'b0000);
    wr(0, 'h594, 32'h8000_0000);
    irqIs("R9 window mask clear self", 4'b1000);
    wr(0, 'h008, 32'h8);
    rd(3, 'h004, d); chk("R7 other ahead of self", d, EOTH);
    rd(3, 'h004, d); chk("R7 self code", d, ESLF);
    rd(3, 'h004, d); chk("R8 both masked after reports", d, 0);
    wr(1, 'h58C, 32'h8000_0001);
    wr(1, 'h594, 32'h8000_0001);
    irqIs("R9 window clear removed both pending", 4'b0000);
    wr(2, 'h590, 32'h1);
    wr(0, 'h008, 32'h8);
    irqIs("R9 window mask set holds other", 4'b0000);
    wr(3, 'h00C, 32'h1);
    wr(3, 'h014, 32'h1);
    irqIs("R4 R5 cpu3 cleanup", 4'b0000);
  endtask

  task automatic t_hw;
    logic [31:0] d;
    wr(0, 'h008, 32'h1);
    @(negedge clk); hwEvtValid = 1'b1; hwEvtWord = 32'h0001_0007;
    rd(0, 'h004, d); chk("R6 hardware word first", d, 32'h0001_0007);
    @(negedge clk); hwEvtValid = 1'b0;
    chk("R6 doorbell not masked", 32'(ipiIrq), 32'h1);
    rd(0, 'h004, d); chk("R7 doorbell after hw drained", d, EOTH);
    wr(0, 'h00C, 32'h1);
    wr(0, 'h014, 32'h1);
    irqIs("R4 cpu0 cleanup", 4'b0000);
  endtask

  task automatic t_conc;
    logic [31:0] d;
    wr(0, 'h008, 32'h1);
    rdWr(0, 0, 'h014, 32'h1, d);
    chk("R10 event sees pre-write state", d, EOTH);
    irqIs("R10 auto-mask beats mask clear", 4'b0000);
    wr(0, 'h00C, 32'h1);
    wr(0, 'h014, 32'h1);
    rdWr(1, 2, 'h008, 32'h2, d);
    chk("R10 read before same-cycle send", d, 0);
    irqIs("R10 send lands unmasked", 4'b0010);
    rd(1, 'h004, d); chk("R10 late send reported", d, EOTH);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    t_reset();
    t_send();
    t_event();
    t_window();
    t_hw();
    t_conc();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule